// File: doc/BRIEF.md
# Buck Regulator Sequencing and Fault Supervisor

This block is the digital controller that steps a single-phase buck regulator through its power-up sequence and guards it against output and supply faults. After enable, it waits in a power-on-reset state until both supply-good flags are high. It then holds off switching for a programmable start-up and calibration delay, counted in microsecond ticks. Next it runs soft start until the reference reaches its target, and finally enters regulation. Power-good is raised only after the output has been in regulation for a programmable settling time.

The analog comparators, current-limit detectors and gate drivers live outside the block. It reads their flags and drives back four things: a gate override (high-side off, low-side on), the choice between the absolute start-up over-voltage threshold and the reference-relative one, a request to ramp the reference to zero, and a fault code. Over-voltage and over-current faults latch until enable is taken low. Under-voltage only masks power-good. Loss of a supply restarts the sequence.

Top module: `vr_supervisor`

## Requirements
- R1: After reset, and one cycle after any cycle with `en` low, the block is in standby: `pgood`=0, `hs_off`=1, `ls_on`=0, `ramp_zero`=0, `fault`=2'b00, `ov_abs_sel`=1, whatever the other inputs are.
- R2: With `en` high and both supplies good, switching stays blocked (`hs_off`=1) until START_US ticks have been counted in the start-up state. Soft start then begins (`hs_off`=0, `ov_abs_sel`=1).
- R3: In soft start, `dac_at_target` moves the block to regulation, which selects the reference-relative OV threshold (`ov_abs_sel`=0). `pgood` rises only after PG_DELAY_US ticks spent in regulation.
- R4: `pgood` is 0 in every state other than regulation.
- R5: `uv_cmp` high during regulation forces `pgood` low on the next cycle without latching. `pgood` returns on the cycle after `uv_cmp` falls.
- R6: `ov_cmp` during soft start or regulation latches fault code 2'b01 with `hs_off`=1 and `ramp_zero`=1. While in this fault, `ls_on` follows `ov_cmp`, and it stays 1 for good once `dac_at_zero` has been seen.
- R7: `oc_fast` during soft start or regulation latches fault code 2'b10 on the next cycle, with `hs_off`=1 and `ls_on`=0.
- R8: `oc_slow` held through OC_SLOW_US ticks latches fault code 2'b10. If it falls before that, its tick count restarts from zero.
- R9: A latched fault holds while `en` stays high, even when the supplies drop. Only `en` low clears it.
- R10: Loss of either supply flag outside a fault stops switching and drops `pgood` on the next cycle. On recovery, the full start-up delay and soft start run again.
- R11: When `ov_cmp` and an over-current flag arrive in the same cycle, the over-voltage fault (2'b01) wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low returns to standby and clears faults |
| vin_ok | input | 1 | Power-stage supply above its undervoltage level |
| vcc_ok | input | 1 | Controller supply above its undervoltage level |
| ov_cmp | input | 1 | Output above the selected OV threshold |
| uv_cmp | input | 1 | Output below the UV window under the reference |
| oc_slow | input | 1 | Current above the timed limit |
| oc_fast | input | 1 | Current above the immediate-trip limit |
| dac_at_target | input | 1 | Reference has reached its target |
| dac_at_zero | input | 1 | Reference has reached zero |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| pgood | output | 1 | Output in regulation and settled |
| hs_off | output | 1 | Force high-side gate off |
| ls_on | output | 1 | Force low-side gate on |
| ov_abs_sel | output | 1 | 1: absolute start-up OV threshold; 0: reference-relative |
| ramp_zero | output | 1 | Request reference ramp to zero |
| fault | output | 2 | 00 none, 01 over-voltage, 10 over-current |

## Verification
All outputs are registered from the next state, so a comparator, fault or enable input shows up at the ports one clock after the edge that samples it. The bench drives inputs just after a falling edge and reads outputs after the next falling edge. Timed windows (start-up delay, power-good settling, slow over-current) finish on the clock after the tick that completes the count. Each tick is therefore issued as a one-cycle pulse followed by one idle cycle, and each check is placed one tick before and exactly at the window edge. Random slow over-current pulse lengths are judged against a bench function of the threshold.

// File: rtl/vr_sup_pkg.sv
package vr_sup_pkg;
  typedef enum logic [2:0] {
    ST_STANDBY = 3'd0,
    ST_POR     = 3'd1,
    ST_START   = 3'd2,
    ST_SOFT    = 3'd3,
    ST_REG     = 3'd4,
    ST_OVF     = 3'd5,
    ST_OCF     = 3'd6
  } sup_state_t;

  localparam logic [1:0] FLT_NONE = 2'b00;
  localparam logic [1:0] FLT_OV   = 2'b01;
  localparam logic [1:0] FLT_OC   = 2'b10;
endpackage

// File: rtl/vr_tick_window.sv
module vr_tick_window #(
  parameter int LIMIT = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);
  assert_clear_on_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);
endmodule

// File: rtl/vr_ov_gate.sv
module vr_ov_gate (
  input  logic clk,
  input  logic rst,
  input  logic in_ov,
  input  logic ov_cmp,
  input  logic dac_at_zero,
  output logic ls_on
);
  logic zero_seen;

  always_ff @(posedge clk) begin
    if (rst || !in_ov) begin
      zero_seen <= 1'b0;
      ls_on     <= 1'b0;
    end else begin
      zero_seen <= zero_seen | dac_at_zero;
      ls_on     <= ov_cmp | zero_seen | dac_at_zero;
    end
  end

  assert_ls_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (in_ov && zero_seen) |=> ls_on);
endmodule

// File: rtl/vr_supervisor.sv
module vr_supervisor
  import vr_sup_pkg::*;
#(
  parameter int START_US    = 10,
  parameter int PG_DELAY_US = 50,
  parameter int OC_SLOW_US  = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       vin_ok,
  input  logic       vcc_ok,
  input  logic       ov_cmp,
  input  logic       uv_cmp,
  input  logic       oc_slow,
  input  logic       oc_fast,
  input  logic       dac_at_target,
  input  logic       dac_at_zero,
  input  logic       tick_us,
  output logic       pgood,
  output logic       hs_off,
  output logic       ls_on,
  output logic       ov_abs_sel,
  output logic       ramp_zero,
  output logic [1:0] fault
);
  sup_state_t st, st_d;
  logic sup_ok, active;
  logic start_done, pg_done, oc_done;

  assign sup_ok = vin_ok & vcc_ok;
  assign active = (st == ST_SOFT) || (st == ST_REG);

  vr_tick_window #(.LIMIT(START_US)) i_start (
    .clk(clk), .rst(rst), .run(st == ST_START), .tick(tick_us), .done(start_done));
  vr_tick_window #(.LIMIT(PG_DELAY_US)) i_pgdly (
    .clk(clk), .rst(rst), .run(st == ST_REG), .tick(tick_us), .done(pg_done));
  vr_tick_window #(.LIMIT(OC_SLOW_US)) i_ocslow (
    .clk(clk), .rst(rst), .run(active && oc_slow), .tick(tick_us), .done(oc_done));

  always_comb begin
    st_d = st;
    if (!en) st_d = ST_STANDBY;
    else begin
      case (st)
        ST_STANDBY: st_d = ST_POR;
        ST_POR:     if (sup_ok) st_d = ST_START;
        ST_START: begin
          if (!sup_ok) st_d = ST_POR;
          else if (start_done) st_d = ST_SOFT;
        end
        ST_SOFT, ST_REG: begin
          if (!sup_ok) st_d = ST_POR;
          else if (ov_cmp) st_d = ST_OVF;
          else if (oc_fast || oc_done) st_d = ST_OCF;
          else if (st == ST_SOFT && dac_at_target) st_d = ST_REG;
        end
        default: st_d = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_STANDBY;
      pgood      <= 1'b0;
      hs_off     <= 1'b1;
      ov_abs_sel <= 1'b1;
      ramp_zero  <= 1'b0;
      fault      <= FLT_NONE;
    end else begin
      st         <= st_d;
      pgood      <= (st_d == ST_REG) && pg_done && !uv_cmp;
      hs_off     <= !((st_d == ST_SOFT) || (st_d == ST_REG));
      ov_abs_sel <= (st_d == ST_STANDBY) || (st_d == ST_POR) ||
                    (st_d == ST_START) || (st_d == ST_SOFT);
      ramp_zero  <= (st_d == ST_OVF);
      fault      <= (st_d == ST_OVF) ? FLT_OV :
                    (st_d == ST_OCF) ? FLT_OC : FLT_NONE;
    end
  end

  vr_ov_gate i_ovgate (
    .clk(clk), .rst(rst), .in_ov(st_d == ST_OVF), .ov_cmp(ov_cmp),
    .dac_at_zero(dac_at_zero), .ls_on(ls_on));

  assert_standby_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pgood && hs_off && !ls_on && !ramp_zero && fault == FLT_NONE));
  assert_pg_only_reg_R4: assert property (@(posedge clk) disable iff (rst)
    pgood |-> (fault == FLT_NONE && !hs_off && !ov_abs_sel));
  assert_ov_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (fault == FLT_OV) |-> (hs_off && ramp_zero && !pgood));
  assert_fast_oc_R7: assert property (@(posedge clk) disable iff (rst)
    (en && sup_ok && active && oc_fast && !ov_cmp) |=> fault == FLT_OC);
  assert_fault_latch_R9: assert property (@(posedge clk) disable iff (rst)
    (fault != FLT_NONE && en) |=> fault == $past(fault));
  assert_ov_first_R11: assert property (@(posedge clk) disable iff (rst)
    (en && sup_ok && active && ov_cmp) |=> fault == FLT_OV);
endmodule

// File: tb/test_vr_supervisor.sv
module test_vr_supervisor;
  localparam int START_US = 10;
  localparam int PG_US    = 50;
  localparam int OC_US    = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, vin_ok = 0, vcc_ok = 0, ov_cmp = 0, uv_cmp = 0;
  logic oc_slow = 0, oc_fast = 0, dac_at_target = 0, dac_at_zero = 0, tick_us = 0;
  logic pgood, hs_off, ls_on, ov_abs_sel, ramp_zero;
  logic [1:0] fault;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vr_supervisor #(.START_US(START_US), .PG_DELAY_US(PG_US), .OC_SLOW_US(OC_US)) i_vr_supervisor (
    .clk(clk), .rst(rst), .en(en), .vin_ok(vin_ok), .vcc_ok(vcc_ok),
    .ov_cmp(ov_cmp), .uv_cmp(uv_cmp), .oc_slow(oc_slow), .oc_fast(oc_fast),
    .dac_at_target(dac_at_target), .dac_at_zero(dac_at_zero), .tick_us(tick_us),
    .pgood(pgood), .hs_off(hs_off), .ls_on(ls_on), .ov_abs_sel(ov_abs_sel),
    .ramp_zero(ramp_zero), .fault(fault));

  function automatic logic [1:0] exp_slow_fault(input int len);
    return (len >= OC_US) ? 2'b10 : 2'b00;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk(input int n);
    repeat (n) begin
      tick_us = 1; cyc(1);
      tick_us = 0; cyc(1);
    end
  endtask

  task automatic chk_off(input string req);
    chk(req, {pgood, hs_off, ls_on, ramp_zero, fault, ov_abs_sel}, {1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1});
  endtask

  task automatic bring_up();
    oc_slow = 0; oc_fast = 0; ov_cmp = 0; uv_cmp = 0; dac_at_zero = 0;
    vin_ok = 1; vcc_ok = 1; dac_at_target = 0;
    en = 0; cyc(1);
    en = 1; cyc(2);
    tk(START_US);
    dac_at_target = 1; cyc(1);
    dac_at_target = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    rst = 0;
    cyc(1);
    chk_off("R1 reset state");

    // random inputs with enable low: outputs stay off
    for (int i = 0; i < 20; i++) begin
      {vin_ok, vcc_ok, ov_cmp, uv_cmp, oc_slow, oc_fast, dac_at_target, dac_at_zero, tick_us} = 9'($urandom);
      cyc(1);
      chk_off("R1 en low random");
    end
    tick_us = 0;

    // sequence through start-up
    ov_cmp = 0; uv_cmp = 0; oc_slow = 0; oc_fast = 0; dac_at_target = 0; dac_at_zero = 0;
    vin_ok = 1; vcc_ok = 1; en = 1;
    cyc(2);
    tk(START_US - 1);
    chk("R2 start delay holds off", hs_off, 1);
    tk(1);
    chk("R2 soft start begins", hs_off, 0);
    chk("R2 absolute OV threshold", ov_abs_sel, 1);
    chk("R4 no pgood in soft start", pgood, 0);

    dac_at_target = 1; cyc(1); dac_at_target = 0;
    chk("R3 relative OV threshold", ov_abs_sel, 0);
    tk(PG_US - 1);
    chk("R3 pgood waits", pgood, 0);
    tk(1);
    chk("R3 pgood rises", pgood, 1);

    uv_cmp = 1; cyc(1);
    chk("R5 uv drops pgood", pgood, 0);
    uv_cmp = 0; cyc(1);
    chk("R5 uv not latched", pgood, 1);

    // over-voltage
    ov_cmp = 1; cyc(1);
    chk("R6 ov fault code", fault, 1);
    chk("R6 ov gates", {hs_off, ls_on, ramp_zero, pgood}, 4'b1110);
    ov_cmp = 0; cyc(1);
    chk("R6 ls follows comparator", ls_on, 0);
    dac_at_zero = 1; cyc(1);
    chk("R6 ls on at zero", ls_on, 1);
    dac_at_zero = 0; cyc(1);
    chk("R6 ls stays on", ls_on, 1);
    vin_ok = 0; cyc(2);
    chk("R9 ov latched through supply loss", fault, 1);
    vin_ok = 1; en = 0; cyc(1);
    chk("R9 en low clears", fault, 0);

    // fast over-current
    bring_up();
    oc_fast = 1; cyc(1); oc_fast = 0;
    chk("R7 fast oc fault", fault, 2);
    chk("R7 fast oc gates", {hs_off, ls_on}, 2'b10);
    cyc(3);
    chk("R9 oc stays latched", fault, 2);

    // priority
    bring_up();
    ov_cmp = 1; oc_fast = 1; cyc(1); ov_cmp = 0; oc_fast = 0;
    chk("R11 ov wins over oc", fault, 1);

    // slow over-current: directed
    bring_up();
    oc_slow = 1;
    tk(OC_US - 1);
    chk("R8 slow oc before limit", fault, 0);
    tk(1);
    chk("R8 slow oc trips", fault, 2);

    bring_up();
    oc_slow = 1; tk(30);
    oc_slow = 0; cyc(1);
    oc_slow = 1; tk(30);
    chk("R8 slow oc timer restarts", fault, 0);
    oc_slow = 0;

    // slow over-current: random lengths
    for (int t = 0; t < 8; t++) begin
      int len;
      len = 40 + int'($urandom % 20);
      bring_up();
      oc_slow = 1; tk(len); oc_slow = 0; cyc(1);
      chk("R8 random slow oc", fault, exp_slow_fault(len));
    end

    // supply loss and restart
    bring_up();
    tk(PG_US);
    chk("R3 pgood before supply loss", pgood, 1);
    vcc_ok = 0; cyc(1);
    chk("R10 supply loss stops", {pgood, hs_off, fault}, {1'b0, 1'b1, 2'b00});
    vcc_ok = 1; cyc(2);
    tk(START_US - 1);
    chk("R10 restart delay again", hs_off, 1);
    tk(1);
    chk("R10 soft start again", {hs_off, ov_abs_sel}, 2'b01);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule